// File: doc/BRIEF.md
# Byte-Per-Pin GPIO Port Controller

This block is a memory-mapped general-purpose I/O controller that drives a bank of pads, 256 pins by default, grouped into ports of 32 pins. Each pin owns a one-byte data register. Software can therefore set, clear or sample a single pin with one byte access, with no read-modify-write of a shared word. Each port also has a 32-bit direction word, and each bit of that word makes the matching pin an output or an input.

Output-enable and output-value vectors go straight from registers to the pad boundary. Pad inputs pass through a two-flop synchronizer before they can be read. The register bus is a plain single-cycle request interface: it has a byte or word size flag, no back-pressure, and returns read data exactly one cycle after the request. The output value of a pin can be loaded while the pin is still an input. When the direction is switched, the pad is then driven with the stored level from the first cycle.

Top module: `pinbyte_gpio`

## Requirements
- R1: After reset every direction bit and every output value is 0. Every `pad_oe` and `pad_out` bit is low, and every direction word reads as 0.
- R2: A byte write (`req_size`=0) to byte address N, with N below the pin count, sets `pad_out[N]` to 1 when `req_wdata[7:0]` is nonzero and to 0 when it is zero. The new level appears at the edge that takes the request, and no other pin changes.
- R3: Pin N belongs to port N/32 at bit N mod 32. A word write (`req_size`=1) to address 0x2000 + 4*p loads the direction word of port p, and bit b of that word drives `pad_oe[32*p+b]` (1 = output).
- R4: A byte read of the address of an output pin returns the driven output value in bit 0, whatever the pad level is. Bits 31:1 are zero.
- R5: A byte read of the address of an input pin returns the pad level after two synchronizer flops. A pad change made before edge k shows up in a read taken at edge k+2, and not in a read taken earlier.
- R6: A value written to a pin while it is an input is kept. When its direction bit is set, the pad is driven with that value in the same cycle as `pad_oe` rises, and reads return it.
- R7: A word read of a direction word returns the value last written to it.
- R8: Accesses outside the map read as zero and have no effect when written. This covers byte addresses at or above the pin count, word accesses in the pin area, byte accesses in the direction area, direction addresses that are not 4-byte aligned, and addresses past the last direction word.
- R9: `rsp_valid` is high in exactly the cycle after each read request and low otherwise. Writes give no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte access, 1 = word access |
| req_addr | input | 14 | Byte address within the block |
| req_wdata | input | 32 | Write data; byte writes use bits 7:0 |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | 256 | Asynchronous pad input levels |
| pad_oe | output | 256 | Pad output enable, one bit per pin |
| pad_out | output | 256 | Pad output value, one bit per pin |

## Verification
Every result has a fixed timing. A write shows up on `pad_oe` or `pad_out` at the edge that accepts it. A read answer arrives one cycle after the request, and a pad change becomes readable only through a read taken two edges later. The bench drives every request on a falling edge and checks the pad vectors at the next falling edge. Each read pushes its expected word into a queue, and a monitor pops that word at the falling edge where `rsp_valid` must be high. For the synchronizer, the bench reads back to back right after a pad change, expecting the old level twice and the new level on the third read.

// File: rtl/pbg_pkg.sv
package pbg_pkg;

   // Width of the register bus data path.
   localparam int WORD_W = 32;

   // Access size flag carried on req_size.
   typedef enum logic {
      ACC_BYTE = 1'b0,
      ACC_WORD = 1'b1
   } acc_e;

   // Result of decoding one request address.
   typedef struct packed {
      logic pin_hit;
      logic dir_hit;
   } hit_t;

endpackage

// File: rtl/pbg_decode.sv
module pbg_decode
   import pbg_pkg::*;
#(
   parameter int NUM_PORTS     = 8,
   parameter int PINS_PER_PORT = 32,
   parameter int ADDR_W        = 14,
   parameter int DIR_BASE      = 'h2000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              size,
   output hit_t              hit,
   output logic [((NUM_PORTS*PINS_PER_PORT) > 1 ? $clog2(NUM_PORTS*PINS_PER_PORT) : 1)-1:0] pin_idx,
   output logic [(NUM_PORTS > 1 ? $clog2(NUM_PORTS) : 1)-1:0] dir_port
);

   localparam int NPINS  = NUM_PORTS * PINS_PER_PORT;
   localparam int PIN_W  = (NPINS > 1) ? $clog2(NPINS) : 1;
   localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
   localparam logic [ADDR_W-1:0] PIN_END_A  = ADDR_W'(NPINS);
   localparam logic [ADDR_W-1:0] DIR_BASE_A = ADDR_W'(DIR_BASE);
   localparam logic [ADDR_W-1:0] DIR_END_A  = ADDR_W'(DIR_BASE + 4 * NUM_PORTS);

   logic aligned;

   always_comb begin
      aligned     = (addr[1:0] == 2'b00);
      hit.pin_hit = (size == ACC_BYTE) && (addr < PIN_END_A);
      hit.dir_hit = (size == ACC_WORD) && aligned
                    && (addr >= DIR_BASE_A) && (addr < DIR_END_A);
      pin_idx     = PIN_W'(addr);
      dir_port    = PORT_W'((addr - DIR_BASE_A) >> 2);
   end

endmodule

// File: rtl/pbg_sync.sv
module pbg_sync #(
   parameter int WIDTH  = 256,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pbg_bank.sv
module pbg_bank #(
   parameter int PINS = 32
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               pin_we,
   input  logic [(PINS > 1 ? $clog2(PINS) : 1)-1:0] pin_bit,
   input  logic                               pin_val,
   input  logic                               dir_we,
   input  logic [PINS-1:0]                    dir_wdata,
   output logic [PINS-1:0]                    dir_q,
   output logic [PINS-1:0]                    out_q
);

   // Direction word: written as a whole.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (dir_we) dir_q <= dir_wdata;
   end

   // Output values: one flop per pin, written one pin at a time.
   for (genvar b = 0; b < PINS; b++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      out_q[b] <= 1'b0;
         else if (pin_we && pin_bit == b) out_q[b] <= pin_val;
      end
   end

endmodule

// File: rtl/pinbyte_gpio.sv
module pinbyte_gpio
   import pbg_pkg::*;
#(
   parameter int NUM_PORTS     = 8,
   parameter int PINS_PER_PORT = 32,
   parameter int ADDR_W        = 14,
   parameter int DIR_BASE      = 'h2000,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 req_valid,
   input  logic                                 req_write,
   input  logic                                 req_size,
   input  logic [ADDR_W-1:0]                    req_addr,
   input  logic [31:0]                          req_wdata,
   output logic                                 rsp_valid,
   output logic [31:0]                          rsp_rdata,
   input  logic [NUM_PORTS*PINS_PER_PORT-1:0]   pad_in,
   output logic [NUM_PORTS*PINS_PER_PORT-1:0]   pad_oe,
   output logic [NUM_PORTS*PINS_PER_PORT-1:0]   pad_out
);

   localparam int NPINS  = NUM_PORTS * PINS_PER_PORT;
   localparam int PIN_W  = (NPINS > 1) ? $clog2(NPINS) : 1;
   localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
   localparam int BIT_W  = (PINS_PER_PORT > 1) ? $clog2(PINS_PER_PORT) : 1;

   // Elaboration-time parameter checks.
   if (PINS_PER_PORT > WORD_W || (PINS_PER_PORT & (PINS_PER_PORT - 1)) != 0) begin : g_bad_pins
      $error("PINS_PER_PORT must be a power of two no larger than the word");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (NPINS > DIR_BASE || (DIR_BASE % 4) != 0) begin : g_bad_base
      $error("DIR_BASE must be word aligned and above the pin area");
   end
   if (DIR_BASE + 4 * NUM_PORTS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the direction words");
   end

   hit_t              hit;
   logic [PIN_W-1:0]  pin_idx;
   logic [PORT_W-1:0] dir_port;
   logic [PORT_W-1:0] pin_port;
   logic [BIT_W-1:0]  pin_bit;
   logic              wr_fire;
   logic              rd_fire;
   logic              pin_val;
   logic [NPINS-1:0]  sync_in;
   logic [PINS_PER_PORT-1:0] dir_words [NUM_PORTS];
   logic [WORD_W-1:0] rd_next;

   pbg_decode #(
      .NUM_PORTS     (NUM_PORTS),
      .PINS_PER_PORT (PINS_PER_PORT),
      .ADDR_W        (ADDR_W),
      .DIR_BASE      (DIR_BASE)
   ) u_decode (
      .addr     (req_addr),
      .size     (req_size),
      .hit      (hit),
      .pin_idx  (pin_idx),
      .dir_port (dir_port)
   );

   pbg_sync #(
      .WIDTH  (NPINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (sync_in)
   );

   assign wr_fire  = req_valid && req_write;
   assign rd_fire  = req_valid && !req_write;
   assign pin_port = PORT_W'(pin_idx >> BIT_W);
   assign pin_bit  = BIT_W'(pin_idx);
   assign pin_val  = |req_wdata[7:0];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic pin_we_p;
      logic dir_we_p;

      assign pin_we_p = wr_fire && hit.pin_hit && (pin_port == p);
      assign dir_we_p = wr_fire && hit.dir_hit && (dir_port == p);

      pbg_bank #(
         .PINS (PINS_PER_PORT)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_we    (pin_we_p),
         .pin_bit   (pin_bit),
         .pin_val   (pin_val),
         .dir_we    (dir_we_p),
         .dir_wdata (PINS_PER_PORT'(req_wdata)),
         .dir_q     (dir_words[p]),
         .out_q     (pad_out[p*PINS_PER_PORT +: PINS_PER_PORT])
      );

      assign pad_oe[p*PINS_PER_PORT +: PINS_PER_PORT] = dir_words[p];
   end

   // Read data selection.
   always_comb begin
      rd_next = '0;
      if (hit.pin_hit) begin
         rd_next[0] = pad_oe[pin_idx] ? pad_out[pin_idx] : sync_in[pin_idx];
      end else if (hit.dir_hit) begin
         rd_next = WORD_W'(dir_words[dir_port]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_fire;
         if (rd_fire) rsp_rdata <= rd_next;
      end
   end

endmodule

// File: rtl/pbg_chk.sv
module pbg_chk
   import pbg_pkg::*;
#(
   parameter int NUM_PORTS     = 8,
   parameter int PINS_PER_PORT = 32,
   parameter int ADDR_W        = 14,
   parameter int DIR_BASE      = 'h2000
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               req_valid,
   input logic                               req_write,
   input logic                               req_size,
   input logic [ADDR_W-1:0]                  req_addr,
   input logic [31:0]                        req_wdata,
   input logic                               rsp_valid,
   input logic [31:0]                        rsp_rdata,
   input logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_oe,
   input logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_out
);

   localparam int NPINS  = NUM_PORTS * PINS_PER_PORT;
   localparam int PIN_W  = (NPINS > 1) ? $clog2(NPINS) : 1;
   localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

   logic                     c_pin_wr;
   logic                     c_dir_wr;
   logic                     wr_pin_q;
   logic [PIN_W-1:0]         wr_pin_idx_q;
   logic                     wr_pin_val_q;
   logic                     wr_dir_q;
   logic [PORT_W-1:0]        wr_dir_port_q;
   logic [PINS_PER_PORT-1:0] wr_dir_word_q;
   logic                     rd_byte_q;

   assign c_pin_wr = req_valid && req_write && (req_size == ACC_BYTE)
                     && (int'(req_addr) < NPINS);
   assign c_dir_wr = req_valid && req_write && (req_size == ACC_WORD)
                     && (int'(req_addr) >= DIR_BASE)
                     && (int'(req_addr) < DIR_BASE + 4 * NUM_PORTS)
                     && (int'(req_addr) % 4 == 0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_pin_q      <= 1'b0;
         wr_pin_idx_q  <= '0;
         wr_pin_val_q  <= 1'b0;
         wr_dir_q      <= 1'b0;
         wr_dir_port_q <= '0;
         wr_dir_word_q <= '0;
         rd_byte_q     <= 1'b0;
      end else begin
         wr_pin_q      <= c_pin_wr;
         wr_pin_idx_q  <= PIN_W'(int'(req_addr));
         wr_pin_val_q  <= (req_wdata[7:0] != 8'h00);
         wr_dir_q      <= c_dir_wr;
         wr_dir_port_q <= PORT_W'((int'(req_addr) - DIR_BASE) / 4);
         wr_dir_word_q <= PINS_PER_PORT'(req_wdata);
         rd_byte_q     <= req_valid && !req_write && (req_size == ACC_BYTE);
      end
   end

   assert_rsp_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);

   assert_no_rsp_otherwise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rsp_valid);

   assert_pin_write_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pin_q |-> (pad_out[wr_pin_idx_q] == wr_pin_val_q));

   assert_dir_word_to_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir_q |-> (pad_oe[wr_dir_port_q*PINS_PER_PORT +: PINS_PER_PORT] == wr_dir_word_q));

   assert_byte_read_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rd_byte_q) |-> ((rsp_rdata >> 1) == 32'd0));

   assert_no_write_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |=> ($stable(pad_out) && $stable(pad_oe)));

endmodule

bind pinbyte_gpio pbg_chk #(
   .NUM_PORTS     (NUM_PORTS),
   .PINS_PER_PORT (PINS_PER_PORT),
   .ADDR_W        (ADDR_W),
   .DIR_BASE      (DIR_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_size  (req_size),
   .req_addr  (req_addr),
   .req_wdata (req_wdata),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out)
);

// File: tb/pinbyte_gpio_tb.sv
`timescale 1ns/100ps
module pinbyte_gpio_tb;
   import pbg_pkg::*;

   localparam int NPIN = 256;
   localparam int AW   = 14;
   localparam int WATCHDOG_CYCLES = 20000;

   typedef struct {
      logic [31:0] val;
      string       tag;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_write = 1'b0;
   logic            req_size = 1'b0;
   logic [AW-1:0]   req_addr = '0;
   logic [31:0]     req_wdata = '0;
   logic            rsp_valid;
   logic [31:0]     rsp_rdata;
   logic [NPIN-1:0] pad_in = '0;
   logic [NPIN-1:0] pad_oe;
   logic [NPIN-1:0] pad_out;

   logic [NPIN-1:0] m_oe = '0;
   logic [NPIN-1:0] m_out = '0;
   exp_t            sbq[$];
   int              checks = 0;
   int              fails = 0;

   always #2.5 clk = ~clk;

   pinbyte_gpio u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_size  (req_size),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .pad_in    (pad_in),
      .pad_oe    (pad_oe),
      .pad_out   (pad_out)
   );

   task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chkv(string tag, logic [NPIN-1:0] act, logic [NPIN-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Driver: all tasks start and end at a falling edge.
   task automatic wr(logic [AW-1:0] a, logic sz, logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_size = sz;
      req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      chk32("R9 no response after write", {31'b0, rsp_valid}, 32'd0);
   endtask

   task automatic rd(logic [AW-1:0] a, logic sz, logic [31:0] exp, string tag);
      exp_t e;
      e.val = exp; e.tag = tag;
      sbq.push_back(e);
      req_valid = 1'b1; req_write = 1'b0; req_size = sz;
      req_addr = a; req_wdata = '0;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   function automatic logic [31:0] pin_exp(int n);
      return {31'b0, m_oe[n] ? m_out[n] : pad_in[n]};
   endfunction

   // Monitor: pops the expected word when a response is due.
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         checks++;
         if (sbq.size() == 0) begin
            fails++;
            $display("FAIL R9 unexpected response: actual %h expected none", rsp_rdata);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            if (rsp_rdata !== e.val) begin
               fails++;
               $display("FAIL %s: actual %h expected %h", e.tag, rsp_rdata, e.val);
            end
         end
      end
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chkv("R1 pad_oe after reset", pad_oe, '0);
      chkv("R1 pad_out after reset", pad_out, '0);
      rd(14'h2000, ACC_WORD, 32'd0, "R1 dir port0 after reset");
      rd(14'h201C, ACC_WORD, 32'd0, "R1 dir port7 after reset");
      rd(14'd9, ACC_BYTE, 32'd0, "R1 pin9 input after reset");

      // R2: byte writes set and clear single pins
      wr(14'd5, ACC_BYTE, 32'h0000_00A5); m_out[5] = 1'b1;
      chkv("R2 pin5 set by nonzero", pad_out, m_out);
      wr(14'd255, ACC_BYTE, 32'h0000_0080); m_out[255] = 1'b1;
      chkv("R2 pin255 set", pad_out, m_out);
      wr(14'd5, ACC_BYTE, 32'hFFFF_FF00); m_out[5] = 1'b0;
      chkv("R2 pin5 cleared by zero low byte", pad_out, m_out);

      // R3 and R7: direction words
      wr(14'h200C, ACC_WORD, 32'h0000_00F0); m_oe[103:100] = 4'hF;
      chkv("R3 port3 dir to pad_oe", pad_oe, m_oe);
      wr(14'h201C, ACC_WORD, 32'h8000_0001); m_oe[224] = 1'b1; m_oe[255] = 1'b1;
      chkv("R3 port7 dir to pad_oe", pad_oe, m_oe);
      rd(14'h200C, ACC_WORD, 32'h0000_00F0, "R7 port3 dir readback");
      rd(14'h201C, ACC_WORD, 32'h8000_0001, "R7 port7 dir readback");

      // R4: output pins read the driven value, not the pad
      pad_in[100] = 1'b1;
      pad_in[255] = 1'b0;
      repeat (3) @(negedge clk);
      rd(14'd100, ACC_BYTE, 32'd0, "R4 output pin100 reads driven 0");
      rd(14'd255, ACC_BYTE, 32'd1, "R4 output pin255 reads driven 1");

      // R6: value written while input appears when switched to output
      wr(14'd40, ACC_BYTE, 32'h0000_0010); m_out[40] = 1'b1;
      chkv("R6 stored value while input", pad_out, m_out);
      chkv("R6 still input", pad_oe, m_oe);
      rd(14'd40, ACC_BYTE, pin_exp(40), "R6 input pin40 reads pad");
      wr(14'h2004, ACC_WORD, 32'h0000_0100); m_oe[40] = 1'b1;
      chkv("R6 oe raised", pad_oe, m_oe);
      chkv("R6 value driven on switch", pad_out, m_out);
      rd(14'd40, ACC_BYTE, 32'd1, "R6 pin40 reads stored value");

      // R5: synchronizer latency
      pad_in[7] = 1'b1;
      rd(14'd7, ACC_BYTE, 32'd0, "R5 pin7 old level at first edge");
      rd(14'd7, ACC_BYTE, 32'd0, "R5 pin7 old level at second edge");
      rd(14'd7, ACC_BYTE, 32'd1, "R5 pin7 new level at third edge");
      pad_in[63:32] = 32'hDEAD_BEEF;
      repeat (3) @(negedge clk);
      rd(14'd32, ACC_BYTE, pin_exp(32), "R5 pin32 pattern");
      rd(14'd36, ACC_BYTE, pin_exp(36), "R5 pin36 pattern");
      rd(14'd63, ACC_BYTE, pin_exp(63), "R5 pin63 pattern");
      rd(14'd40, ACC_BYTE, pin_exp(40), "R4 pin40 output over pad");

      // R8: unmapped accesses
      rd(14'h0100, ACC_BYTE, 32'd0, "R8 byte past pins");
      rd(14'd4, ACC_WORD, 32'd0, "R8 word in pin area");
      rd(14'h2000, ACC_BYTE, 32'd0, "R8 byte in dir area");
      rd(14'h2006, ACC_WORD, 32'd0, "R8 misaligned dir word");
      rd(14'h2020, ACC_WORD, 32'd0, "R8 word past dirs");
      rd(14'h3FFC, ACC_WORD, 32'd0, "R8 top of space");
      wr(14'h0100, ACC_BYTE, 32'hFFFF_FFFF);
      wr(14'd8, ACC_WORD, 32'hFFFF_FFFF);
      wr(14'h2000, ACC_BYTE, 32'hFFFF_FFFF);
      wr(14'h2002, ACC_WORD, 32'hFFFF_FFFF);
      wr(14'h2020, ACC_WORD, 32'hFFFF_FFFF);
      wr(14'h1FFC, ACC_WORD, 32'hFFFF_FFFF);
      chkv("R8 pad_oe unchanged by unmapped writes", pad_oe, m_oe);
      chkv("R8 pad_out unchanged by unmapped writes", pad_out, m_out);
      rd(14'h2000, ACC_WORD, m_oe[31:0], "R8 port0 dir unchanged");
      rd(14'd8, ACC_BYTE, pin_exp(8), "R8 pin8 unchanged");

      repeat (3) @(negedge clk);
      checks++;
      if (sbq.size() != 0) begin
         fails++;
         $display("FAIL R9 responses missing: actual %0d pending expected 0", sbq.size());
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule